// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Programmer

This block holds the four threshold registers that the flag logic of a two-FIFO buffer compares against: an almost-empty and an almost-full offset for each FIFO. The first FIFO's pair is named `y1` and `x1`, the second FIFO's pair `y2` and `x2`. The width of each offset is the number of address bits of one FIFO, so it follows the depth parameter.

The way the registers are filled is chosen by a three-bit select input. The block samples it on the first clock edge after the main master reset is released. There are three methods. A preset method writes one of five power-of-two defaults into all four registers at once. A parallel method takes four writes from the wide data port, using the low bits of each word. A serial method shifts one bit per clock edge while an active-low enable is asserted. A done output tells the flag logic that programming is complete. A separate master reset for the second FIFO zeroes only that FIFO's pair of registers.

Top module: `flag_ofs_loader`

## Requirements
- R1: While `mrst1_n` is low, all four offset outputs read zero and `prog_done` is low.
- R2: `ofs_sel` is sampled on the first rising clock edge at which `mrst1_n` is high. Later changes of `ofs_sel` have no effect until the next master reset.
- R3: The select codes 3'b010, 3'b011, 3'b100, 3'b101 and 3'b110 preload all four offsets with 8, 16, 64, 256 and 1024 respectively. The code 3'b111 also preloads 8. With any of these codes, `prog_done` rises on that same sampling edge.
- R4: Select code 3'b000 picks serial loading. Each rising edge with `ser_en_n` low shifts `ser_bit` into a single chain running y1, x1, y2, x2, each register MSB first. The first bit shifted in ends up as the y1 MSB and the last one as the x2 LSB. Edges with `ser_en_n` high shift nothing.
- R5: In serial mode, `prog_done` rises on the edge that takes in bit number 4*OFS_W. With the default depth of 2048 that is 44 bits, where OFS_W = log2(DEPTH).
- R6: Once `prog_done` is high, serial bits and parallel writes are ignored and `prog_done` stays high until the next master reset.
- R7: Select code 3'b001 picks parallel loading. Each rising edge with `par_we` high copies `par_data[OFS_W-1:0]` into y1, x1, y2 and x2 in that order. `prog_done` rises with the fourth write. `ser_en_n` has no effect in this mode.
- R8: A rising edge with `mrst2_n` low sets x2 and y2 to zero and leaves y1, x1 and `prog_done` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst1_n | input | 1 | Main master reset, active low, asynchronous assertion |
| mrst2_n | input | 1 | Master reset of the second FIFO, active low, sampled on clk |
| ofs_sel | input | 3 | Method and default select, sampled after reset release |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial data bit |
| par_we | input | 1 | Parallel write strobe |
| par_data | input | DATA_W | Wide data word; low OFS_W bits are used |
| y1 | output | OFS_W | Almost-empty offset, first FIFO |
| x1 | output | OFS_W | Almost-full offset, first FIFO |
| y2 | output | OFS_W | Almost-empty offset, second FIFO |
| x2 | output | OFS_W | Almost-full offset, second FIFO |
| prog_done | output | 1 | Programming complete |

## Verification
The bench builds the block with DEPTH = 2048 and DATA_W = 36. This gives 11-bit offsets and a 44-bit serial chain, so the largest default, 1024, sets the top bit of each register. A 36-bit word with nonzero upper bits shows that only the low 11 bits reach a register. A behavioural model compares all outputs on every clock. The stimulus covers every select code, serial shifting with idle gaps and surplus bits, parallel writes with gaps and surplus writes, and a second-FIFO reset applied after programming.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_PRESET   = 2'd1,
        M_PARALLEL = 2'd2,
        M_SERIAL   = 2'd3
    } method_e;

    localparam int NUM_OFS = 4;

endpackage

// File: rtl/ofs_sel_decode.sv
module ofs_sel_decode
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [2:0]       sel,
    output method_e          meth,
    output logic [OFS_W-1:0] preset_val
);

    // Exponents of the power-of-two defaults
    always_comb begin
        meth       = M_PRESET;
        preset_val = '0;
        case (sel)
            3'b000:  meth = M_SERIAL;
            3'b001:  meth = M_PARALLEL;
            3'b010:  preset_val = OFS_W'(32'd1 << 3);
            3'b011:  preset_val = OFS_W'(32'd1 << 4);
            3'b100:  preset_val = OFS_W'(32'd1 << 6);
            3'b101:  preset_val = OFS_W'(32'd1 << 8);
            3'b110:  preset_val = OFS_W'(32'd1 << 10);
            default: preset_val = OFS_W'(32'd1 << 3);
        endcase
    end

endmodule

// File: rtl/ofs_step_counter.sv
module ofs_step_counter #(
    parameter int LIMIT = 44,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step && (cnt_q != CW'(LIMIT)))
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = step && (cnt_q == CW'(LIMIT - 1));

    // R5: the count never passes the chain length
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
    import ofs_pkg::*;
#(
    parameter int  DEPTH   = 2048,
    parameter int  DATA_W  = 36,
    localparam int OFS_W   = $clog2(DEPTH),
    localparam int CHAIN_W = NUM_OFS * OFS_W,
    localparam int PCW     = $clog2(NUM_OFS + 1)
) (
    input  logic              clk,
    input  logic              mrst1_n,
    input  logic              mrst2_n,
    input  logic [2:0]        ofs_sel,
    input  logic              ser_en_n,
    input  logic              ser_bit,
    input  logic              par_we,
    input  logic [DATA_W-1:0] par_data,
    output logic [OFS_W-1:0]  y1,
    output logic [OFS_W-1:0]  x1,
    output logic [OFS_W-1:0]  y2,
    output logic [OFS_W-1:0]  x2,
    output logic              prog_done
);

    // chain layout, high to low: y1, x1, y2, x2
    typedef struct packed {
        method_e              meth;
        logic                 armed;
        logic                 done;
        logic [CHAIN_W-1:0]   chain;
    } state_t;

    state_t st_d, st_q;

    method_e            dec_meth;
    logic [OFS_W-1:0]   dec_val;
    logic               ser_step, ser_last;
    logic               par_step, par_last;
    logic [PCW-1:0]     par_cnt;
    logic [$clog2(CHAIN_W+1)-1:0] ser_cnt;

    ofs_sel_decode #(.OFS_W(OFS_W)) u_dec (
        .sel        (ofs_sel),
        .meth       (dec_meth),
        .preset_val (dec_val)
    );

    assign ser_step = st_q.armed && (st_q.meth == M_SERIAL)
                      && !st_q.done && !ser_en_n;
    assign par_step = st_q.armed && (st_q.meth == M_PARALLEL)
                      && !st_q.done && par_we;

    ofs_step_counter #(.LIMIT(CHAIN_W)) u_ser_cnt (
        .clk   (clk),
        .rst_n (mrst1_n),
        .step  (ser_step),
        .cnt   (ser_cnt),
        .last  (ser_last)
    );

    ofs_step_counter #(.LIMIT(NUM_OFS)) u_par_cnt (
        .clk   (clk),
        .rst_n (mrst1_n),
        .step  (par_step),
        .cnt   (par_cnt),
        .last  (par_last)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.meth  = dec_meth;
            st_d.done  = (dec_meth == M_PRESET);
            if (dec_meth == M_PRESET)
                st_d.chain = {NUM_OFS{dec_val}};
        end else if (ser_step) begin
            st_d.chain = {st_q.chain[CHAIN_W-2:0], ser_bit};
            if (ser_last) st_d.done = 1'b1;
        end else if (par_step) begin
            for (int k = 0; k < NUM_OFS; k++) begin
                if (par_cnt == PCW'(k))
                    st_d.chain[CHAIN_W-1-k*OFS_W -: OFS_W] = par_data[OFS_W-1:0];
            end
            if (par_last) st_d.done = 1'b1;
        end
        if (!mrst2_n)
            st_d.chain[2*OFS_W-1:0] = '0;
    end

    always_ff @(posedge clk or negedge mrst1_n) begin
        if (!mrst1_n) st_q <= '{meth: M_IDLE, armed: 1'b0, done: 1'b0, chain: '0};
        else          st_q <= st_d;
    end

    assign y1        = st_q.chain[4*OFS_W-1 -: OFS_W];
    assign x1        = st_q.chain[3*OFS_W-1 -: OFS_W];
    assign y2        = st_q.chain[2*OFS_W-1 -: OFS_W];
    assign x2        = st_q.chain[OFS_W-1:0];
    assign prog_done = st_q.done;

    // R6: done holds until master reset
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!mrst1_n)
        prog_done |=> prog_done);

    // R6: first-FIFO offsets frozen once done
    p_hold_first_r6: assert property (@(posedge clk) disable iff (!mrst1_n)
        prog_done |=> $stable({y1, x1}));

    // R8: second-FIFO reset zeroes its pair
    p_mr2_clear_r8: assert property (@(posedge clk) disable iff (!mrst1_n)
        !mrst2_n |=> (x2 == '0) && (y2 == '0));

    // R4: a taken serial bit lands in the x2 LSB
    p_ser_lsb_r4: assert property (@(posedge clk) disable iff (!mrst1_n)
        (ser_step && mrst2_n) |=> (x2[0] == $past(ser_bit)));

    // R1: done is never set while nothing is armed
    p_done_armed_r1: assert property (@(posedge clk) disable iff (!mrst1_n)
        prog_done |-> st_q.armed);

endmodule

// File: tb/tb_flag_ofs_loader.sv
`timescale 1ns/1ps
module tb_flag_ofs_loader;

    localparam int DEPTH  = 2048;
    localparam int DATA_W = 36;
    localparam int W      = $clog2(DEPTH);
    localparam int CHAIN  = 4 * W;
    localparam int MASK   = (1 << W) - 1;

    logic clk = 1'b0;
    logic mrst1_n = 1'b0, mrst2_n = 1'b0;
    logic [2:0] ofs_sel = 3'b010;
    logic ser_en_n = 1'b1, ser_bit = 1'b0, par_we = 1'b0;
    logic [DATA_W-1:0] par_data = '0;
    logic [W-1:0] y1, x1, y2, x2;
    logic prog_done;

    int total = 0, bad = 0;
    string phase = "R1";

    // behavioural reference state
    int m_y1 = 0, m_x1 = 0, m_y2 = 0, m_x2 = 0, m_cnt = 0, m_meth = 0;
    bit m_armed = 0, m_done = 0;

    always #2.5 clk = ~clk;

    flag_ofs_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk(clk), .mrst1_n(mrst1_n), .mrst2_n(mrst2_n), .ofs_sel(ofs_sel),
        .ser_en_n(ser_en_n), .ser_bit(ser_bit), .par_we(par_we),
        .par_data(par_data), .y1(y1), .x1(x1), .y2(y2), .x2(x2),
        .prog_done(prog_done)
    );

    function automatic int preset_of(input logic [2:0] s);
        case (s)
            3'b010: return 8;
            3'b011: return 16;
            3'b100: return 64;
            3'b101: return 256;
            3'b110: return 1024;
            default: return 8;
        endcase
    endfunction

    // model: meth 0 idle, 1 preset, 2 parallel, 3 serial
    always @(posedge clk) begin
        if (!mrst1_n) begin
            m_y1 = 0; m_x1 = 0; m_y2 = 0; m_x2 = 0;
            m_cnt = 0; m_meth = 0; m_armed = 0; m_done = 0;
        end else begin
            if (!m_armed) begin
                m_armed = 1;
                if (ofs_sel == 3'b000) m_meth = 3;
                else if (ofs_sel == 3'b001) m_meth = 2;
                else begin
                    m_meth = 1; m_done = 1;
                    m_y1 = preset_of(ofs_sel); m_x1 = m_y1; m_y2 = m_y1; m_x2 = m_y1;
                end
            end else if (m_meth == 3 && !m_done && !ser_en_n) begin
                int ny1, nx1, ny2, nx2;
                ny1 = ((m_y1 << 1) | (m_x1 >> (W-1))) & MASK;
                nx1 = ((m_x1 << 1) | (m_y2 >> (W-1))) & MASK;
                ny2 = ((m_y2 << 1) | (m_x2 >> (W-1))) & MASK;
                nx2 = ((m_x2 << 1) | int'(ser_bit)) & MASK;
                m_y1 = ny1; m_x1 = nx1; m_y2 = ny2; m_x2 = nx2;
                m_cnt++;
                if (m_cnt == CHAIN) m_done = 1;
            end else if (m_meth == 2 && !m_done && par_we) begin
                int v;
                v = int'(par_data[W-1:0]);
                case (m_cnt)
                    0: m_y1 = v;
                    1: m_x1 = v;
                    2: m_y2 = v;
                    default: m_x2 = v;
                endcase
                m_cnt++;
                if (m_cnt == 4) m_done = 1;
            end
            if (!mrst2_n) begin m_x2 = 0; m_y2 = 0; end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock, then compare every output against the model
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(int'(y1) == m_y1, phase, "y1", int'(y1), m_y1);
        check(int'(x1) == m_x1, phase, "x1", int'(x1), m_x1);
        check(int'(y2) == m_y2, phase, "y2", int'(y2), m_y2);
        check(int'(x2) == m_x2, phase, "x2", int'(x2), m_x2);
        check(prog_done == m_done, phase, "done", int'(prog_done), int'(m_done));
    endtask

    task automatic do_reset(input logic [2:0] s);
        mrst1_n = 1'b0; mrst2_n = 1'b0; ofs_sel = s;
        ser_en_n = 1'b1; par_we = 1'b0;
        repeat (4) tick();
        mrst1_n = 1'b1; mrst2_n = 1'b1;
        tick();
    endtask

    localparam logic [63:0] PAT = 64'hA5C3_96F0_1E7B_2D48;

    initial begin
        // R1: reset state
        phase = "R1";
        repeat (3) tick();
        check(y1 == '0 && x1 == '0 && y2 == '0 && x2 == '0, "R1", "zero offsets",
              int'(y1 | x1 | y2 | x2), 0);
        check(prog_done == 1'b0, "R1", "done low in reset", int'(prog_done), 0);
        mrst1_n = 1'b1; mrst2_n = 1'b1;
        phase = "R2";
        tick();
        // R2: select changes after sampling are ignored
        ofs_sel = 3'b110;
        repeat (3) tick();
        check(int'(y1) == 8, "R2", "sel held after sampling", int'(y1), 8);

        // R3: every preset code, including the reserved alias
        phase = "R3";
        for (int c = 2; c < 8; c++) begin
            do_reset(3'(c));
            check(int'(x2) == preset_of(3'(c)) && prog_done, "R3", "preset value",
                  int'(x2), preset_of(3'(c)));
            tick();
        end

        // R4/R5: serial load with idle gaps, then surplus bits (R6)
        phase = "R4";
        do_reset(3'b000);
        for (int i = 0; i < CHAIN; i++) begin
            if (i % 5 == 2) begin
                ser_en_n = 1'b1; ser_bit = ~PAT[63-i];
                phase = "R5"; tick(); phase = "R4";
            end
            ser_en_n = 1'b0; ser_bit = PAT[63-i];
            if (i == CHAIN - 2) begin
                tick();
                check(prog_done == 1'b0, "R5", "done before last bit", int'(prog_done), 0);
            end else begin
                tick();
            end
        end
        check(prog_done == 1'b1, "R5", "done after chain length", int'(prog_done), 1);
        check(int'(y1) == int'(PAT[63:53]), "R4", "first bits into y1", int'(y1), int'(PAT[63:53]));
        check(int'(x2) == int'(PAT[30:20]), "R4", "last bits into x2", int'(x2), int'(PAT[30:20]));
        phase = "R6";
        for (int i = 0; i < 6; i++) begin
            ser_bit = i[0];
            tick();
        end
        ser_en_n = 1'b1;
        check(int'(x1) == int'(PAT[52:42]), "R6", "surplus serial ignored", int'(x1), int'(PAT[52:42]));

        // R7: parallel load with gaps; ser_en_n toggling has no effect
        phase = "R7";
        do_reset(3'b001);
        ser_en_n = 1'b0; ser_bit = 1'b1;
        par_we = 1'b1; par_data = 36'hF_0000_0123; tick();
        par_we = 1'b0; tick();
        par_we = 1'b1; par_data = 36'hA_BCDE_F7FF; tick();
        par_data = 36'h0_0000_0001; tick();
        check(prog_done == 1'b0, "R7", "done before fourth write", int'(prog_done), 0);
        par_we = 1'b0; tick();
        par_we = 1'b1; par_data = 36'h5_5555_0555; tick();
        check(int'(y1) == 12'h123 && int'(x1) == 12'h7FF && int'(y2) == 1,
              "R7", "parallel order y1", int'(y1), 12'h123);
        check(int'(x2) == 12'h555 && prog_done, "R7", "parallel x2", int'(x2), 12'h555);
        phase = "R6";
        par_data = 36'h0_0000_0000; tick(); tick();
        par_we = 1'b0; ser_en_n = 1'b1;
        check(int'(y1) == 12'h123, "R6", "surplus write ignored", int'(y1), 12'h123);

        // R8: second-FIFO reset after programming
        phase = "R8";
        mrst2_n = 1'b0; tick();
        mrst2_n = 1'b1; tick();
        check(x2 == '0 && y2 == '0, "R8", "x2/y2 cleared", int'(x2 | y2), 0);
        check(int'(x1) == 12'h7FF && prog_done, "R8", "x1 kept", int'(x1), 12'h7FF);

        // R1: reset again mid-run
        phase = "R1";
        mrst1_n = 1'b0; tick(); tick();
        check(prog_done == 1'b0 && y1 == '0, "R1", "reassert clears", int'(y1), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule